// File: doc/BRIEF.md
# Pixel Word Unpacker and Panel Bus Formatter

This block sits between a pixel word FIFO and a display timing generator. Each 32-bit word holds either two 16-bit RGB565 pixels or one 24-bit colour pixel. The block hands out one element per pixel request from the timing generator. Each element is shaped for the selected panel data bus of 8, 16, 18 or 24 bits. Optional steps swap the red and blue components, invert the driven bus bits, and reduce 24-bit colour to 6 bits per component for narrower buses.

The word input uses a valid/ready handshake. A word transfers on a clock edge where both `word_valid` and `word_ready` are high. The block holds a single word. `word_ready` is high when that holder is empty, or when the holder's last element is taken in the same cycle. While `word_ready` is low, the source must keep `word_valid` and `word_data` steady. Control inputs are plain levels. The configuration is changed only while `fifo_clear` is asserted.

`fifo_clear` throws away any residual word, so a new frame never starts part-way through a word. The pixel side does not wait. A request that finds no data gives a zero pixel and raises the underflow flag.

Top module: `pix_unpacker`

## Requirements
- R1: After reset, `pix_data` is 0, `pix_underflow` is 0 and `word_ready` is 1.
- R2: A word is taken when `word_valid` and `word_ready` are both high. `word_ready` is 1 when the holder is empty or its last element is being consumed by a request in that cycle, and 0 otherwise, so a waiting word stays at the input.
- R3: With `cfg_byte_mask` = 4'hF the layout is packed. A word holds two elements, the halfword in bits 15:0 first and bits 31:16 second. Each request consumes one element, and its formatted value appears on `pix_data` on the clock edge that samples the request.
- R4: For a packed halfword (red 15:11, green 10:5, blue 4:0), the 16-bit bus code 0 drives {r,g,b} on bits 15:0. The 18-bit code 2 drives {r,0,g,b,0} on bits 17:0. The 24-bit code 3 drives {r,000,g,00,b,000} on bits 23:0.
- R5: Any mask other than 4'hF (normally 4'h7) means one pixel per word, taken from bits 23:0 (red 23:16, green 15:8, blue 7:0). The 24-bit bus drives all 24 bits. The 16-bit and 18-bit buses drive the low 6 bits of each component as {r,g,b} on bits 17:0. Bits above the bus width are always 0, so the 16-bit bus keeps only bits 15:0.
- R6: On the 8-bit bus (code 1) with packed layout, each request outputs one byte on bits 7:0, lowest byte first, four per word.
- R7: The 8-bit bus with one-pixel-per-word layout is unsupported. `cfg_unsupported` is 1, and each request consumes a pixel but drives 0.
- R8: With `cfg_swap_rb` = 1, the red and blue components trade places in all colour modes. Byte mode is not affected.
- R9: With `cfg_invert` = 1, every bit inside the bus width is inverted. Bits above the width stay 0, and zero outputs from underflow or an unsupported mode are not inverted.
- R10: A request while no element is held gives `pix_data` = 0 and `pix_underflow` = 1 on that edge. `pix_underflow` is 0 on any edge without an underflowing request.
- R11: On an edge without a request, `pix_data` keeps its value and no element is consumed.
- R12: While `fifo_clear` is high, the held word is discarded, `word_ready` is 1, offered words are dropped, and `pix_data` and `pix_underflow` become 0 on each such edge. The next request after the clear underflows unless a new word has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | Source offers a word |
| word_ready | output | 1 | Block accepts the offered word this cycle |
| word_data | input | 32 | Pixel word |
| fifo_clear | input | 1 | Discard residual data |
| cfg_bus_width | input | 2 | 0 = 16 bit, 1 = 8 bit, 2 = 18 bit, 3 = 24 bit |
| cfg_byte_mask | input | 4 | 4'hF packed two per word, otherwise one per word |
| cfg_swap_rb | input | 1 | Exchange red and blue |
| cfg_invert | input | 1 | Invert driven bus bits |
| pix_req | input | 1 | Pixel request from the timing block |
| pix_data | output | 24 | Panel data, registered |
| pix_underflow | output | 1 | Request found no data |
| cfg_unsupported | output | 1 | Selected bus and layout pair is unsupported |

## Verification
The assertions check on every cycle that the input is ready whenever the holder is empty, and that a waiting word is not disturbed. They also check that a clear empties the holder and zeros the output, that an underflow always shows zero data and follows a request, and that the output holds when no request is made. The ordering of halfwords and bytes within a word cannot be shown by these assertions, and neither can the bit placement for each bus width or the effect of swap and inversion. The bench's reference model, fed with many words under several request rates, shows those through the exact pixel values.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned PIX_W   = 24;
  localparam int unsigned BYTES_W = WORD_W / 8;
  localparam int unsigned IDX_W   = $clog2(BYTES_W);
  localparam int unsigned HALF_W  = WORD_W / 2;

  typedef enum logic [1:0] {
    BUS16 = 2'd0,
    BUS8  = 2'd1,
    BUS18 = 2'd2,
    BUS24 = 2'd3
  } bus_w_e;

  function automatic logic [PIX_W-1:0] bus_mask(input bus_w_e bw);
    case (bw)
      BUS8:    bus_mask = 24'h0000FF;
      BUS16:   bus_mask = 24'h00FFFF;
      BUS18:   bus_mask = 24'h03FFFF;
      default: bus_mask = 24'hFFFFFF;
    endcase
  endfunction
endpackage

// File: rtl/pxu_word_hold.sv
module pxu_word_hold
  import pxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  input  logic              packed_mode,
  input  logic              byte_mode,
  input  logic              take,
  output logic              full,
  output logic [PIX_W-1:0]  elem
);
  logic [WORD_W-1:0] hold_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  last_idx;
  logic              at_last;
  logic              pop_last;
  logic              accept;

  always_comb begin
    if (byte_mode)        last_idx = IDX_W'(BYTES_W - 1);
    else if (packed_mode) last_idx = IDX_W'(1);
    else                  last_idx = '0;
  end

  assign at_last    = (idx_q == last_idx);
  assign pop_last   = take & at_last;
  assign word_ready = clear | ~full | pop_last;
  assign accept     = word_valid & word_ready & ~clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      idx_q  <= '0;
      full   <= 1'b0;
    end else if (clear) begin
      idx_q <= '0;
      full  <= 1'b0;
    end else begin
      if (take) idx_q <= at_last ? '0 : idx_q + IDX_W'(1);
      if (accept) begin
        hold_q <= word_data;
        full   <= 1'b1;
      end else if (pop_last) begin
        full <= 1'b0;
      end
    end
  end

  always_comb begin
    if (byte_mode)        elem = PIX_W'(hold_q[{idx_q, 3'b000} +: 8]);
    else if (packed_mode) elem = PIX_W'(hold_q[{idx_q[0], 4'b0000} +: HALF_W]);
    else                  elem = hold_q[PIX_W-1:0];
  end

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> word_ready); // R2
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take && !clear) |=> (full && $stable(hold_q))); // R2
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !full); // R12
endmodule

// File: rtl/pxu_format.sv
module pxu_format
  import pxu_pkg::*;
(
  input  logic [PIX_W-1:0] elem,
  input  logic             packed_mode,
  input  logic             byte_mode,
  input  bus_w_e           bus,
  input  logic             swap_rb,
  input  logic             invert,
  output logic [PIX_W-1:0] pix,
  output logic             unsupported
);
  logic [4:0]       r5, b5;
  logic [5:0]       g6;
  logic [7:0]       r8, g8, b8;
  logic [PIX_W-1:0] raw;
  logic [PIX_W-1:0] mask;

  assign unsupported = (bus == BUS8) && !packed_mode;
  assign mask        = bus_mask(bus);

  always_comb begin
    r5 = swap_rb ? elem[4:0]   : elem[15:11];
    b5 = swap_rb ? elem[15:11] : elem[4:0];
    g6 = elem[10:5];
    r8 = swap_rb ? elem[7:0]   : elem[23:16];
    b8 = swap_rb ? elem[23:16] : elem[7:0];
    g8 = elem[15:8];
    raw = '0;
    if (byte_mode) begin
      raw = {16'h0, elem[7:0]};
    end else if (packed_mode) begin
      case (bus)
        BUS16:   raw = {8'h0, r5, g6, b5};
        BUS18:   raw = {6'h0, r5, 1'b0, g6, b5, 1'b0};
        BUS24:   raw = {r5, 3'b000, g6, 2'b00, b5, 3'b000};
        default: raw = '0;
      endcase
    end else begin
      case (bus)
        BUS24:   raw = {r8, g8, b8};
        BUS16,
        BUS18:   raw = {6'h0, r8[5:0], g8[5:0], b8[5:0]};
        default: raw = '0;
      endcase
    end
  end

  assign pix = unsupported ? '0 : ((raw ^ (invert ? mask : '0)) & mask);
endmodule

// File: rtl/pix_unpacker.sv
module pix_unpacker
  import pxu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_valid,
  output logic        word_ready,
  input  logic [31:0] word_data,
  input  logic        fifo_clear,
  input  logic [1:0]  cfg_bus_width,
  input  logic [3:0]  cfg_byte_mask,
  input  logic        cfg_swap_rb,
  input  logic        cfg_invert,
  input  logic        pix_req,
  output logic [23:0] pix_data,
  output logic        pix_underflow,
  output logic        cfg_unsupported
);
  bus_w_e           bus;
  logic             packed_mode;
  logic             byte_mode;
  logic             full;
  logic             take;
  logic [PIX_W-1:0] elem;
  logic [PIX_W-1:0] fmt_pix;

  assign bus         = bus_w_e'(cfg_bus_width);
  assign packed_mode = (cfg_byte_mask == 4'hF);
  assign byte_mode   = packed_mode && (bus == BUS8);
  assign take        = pix_req & full & ~fifo_clear;

  pxu_word_hold u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (fifo_clear),
    .word_valid  (word_valid),
    .word_ready  (word_ready),
    .word_data   (word_data),
    .packed_mode (packed_mode),
    .byte_mode   (byte_mode),
    .take        (take),
    .full        (full),
    .elem        (elem)
  );

  pxu_format u_fmt (
    .elem        (elem),
    .packed_mode (packed_mode),
    .byte_mode   (byte_mode),
    .bus         (bus),
    .swap_rb     (cfg_swap_rb),
    .invert      (cfg_invert),
    .pix         (fmt_pix),
    .unsupported (cfg_unsupported)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_data      <= '0;
      pix_underflow <= 1'b0;
    end else if (fifo_clear) begin
      pix_data      <= '0;
      pix_underflow <= 1'b0;
    end else if (pix_req) begin
      pix_data      <= full ? fmt_pix : '0;
      pix_underflow <= ~full;
    end else begin
      pix_underflow <= 1'b0;
    end
  end

  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pix_underflow |-> (pix_data == '0)); // R10
  AST_UNDERFLOW_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_req |=> !pix_underflow); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_req && !fifo_clear) |=> $stable(pix_data)); // R11
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |=> (pix_data == '0 && !pix_underflow)); // R12
endmodule

// File: tb/pix_unpacker_tb.sv
`timescale 1ns/1ps
module pix_unpacker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [31:0] word_data = '0;
  logic        fifo_clear = 1'b0;
  logic [1:0]  cfg_bus_width = 2'd0;
  logic [3:0]  cfg_byte_mask = 4'hF;
  logic        cfg_swap_rb = 1'b0;
  logic        cfg_invert = 1'b0;
  logic        pix_req = 1'b0;
  logic [23:0] pix_data;
  logic        pix_underflow;
  logic        cfg_unsupported;

  int checks = 0;
  int failures = 0;
  string tag_cur = "R3";
  logic [23:0] mq[$];
  logic [23:0] exp_d = '0;
  logic        exp_uf = 1'b0;
  bit          model_on = 1'b0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  pix_unpacker u_dut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .fifo_clear(fifo_clear), .cfg_bus_width(cfg_bus_width),
    .cfg_byte_mask(cfg_byte_mask), .cfg_swap_rb(cfg_swap_rb), .cfg_invert(cfg_invert),
    .pix_req(pix_req), .pix_data(pix_data), .pix_underflow(pix_underflow),
    .cfg_unsupported(cfg_unsupported)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [23:0] ref_fmt(input logic [23:0] e, input bit pk,
      input logic [1:0] bw, input bit sw, input bit inv);
    int w, r, g, b, t;
    longint m, raw;
    w = (bw == 2'd0) ? 16 : (bw == 2'd1) ? 8 : (bw == 2'd2) ? 18 : 24;
    m = (64'd1 << w) - 1;
    if (!pk && bw == 2'd1) return 24'h0;
    if (pk && bw == 2'd1) raw = e & 8'hFF;
    else if (pk) begin
      r = int'(e[15:11]); g = int'(e[10:5]); b = int'(e[4:0]);
      if (sw) begin t = r; r = b; b = t; end
      if (bw == 2'd0)      raw = (r << 11) | (g << 5) | b;
      else if (bw == 2'd2) raw = (r << 13) | (g << 6) | (b << 1);
      else                 raw = (r << 19) | (g << 10) | (b << 3);
    end else begin
      r = int'(e[23:16]); g = int'(e[15:8]); b = int'(e[7:0]);
      if (sw) begin t = r; r = b; b = t; end
      if (bw == 2'd3) raw = (r << 16) | (g << 8) | b;
      else raw = ((r % 64) << 12) | ((g % 64) << 6) | (b % 64);
    end
    raw = raw & m;
    if (inv) raw = raw ^ m;
    return 24'(raw);
  endfunction

  // reference model: element queue, updated at each clock edge
  always @(posedge clk) begin
    bit pk, rdy;
    logic [23:0] e;
    if (rst_n && model_on) begin
      pk  = (cfg_byte_mask == 4'hF);
      rdy = fifo_clear || mq.size() == 0 || (pix_req && mq.size() == 1);
      chk(word_ready == rdy, "R2", "word_ready", word_ready, rdy);
      chk(cfg_unsupported == (cfg_bus_width == 2'd1 && !pk), "R7", "cfg_unsupported",
          cfg_unsupported, (cfg_bus_width == 2'd1 && !pk));
      if (fifo_clear) begin
        mq.delete();
        exp_d  = '0;
        exp_uf = 1'b0;
      end else begin
        exp_uf = 1'b0;
        if (pix_req) begin
          if (mq.size() == 0) begin
            exp_d  = '0;
            exp_uf = 1'b1;
          end else begin
            e = mq.pop_front();
            exp_d = ref_fmt(e, pk, cfg_bus_width, cfg_swap_rb, cfg_invert);
          end
        end
        if (word_valid && rdy) begin
          if (pk && cfg_bus_width == 2'd1)
            for (int k = 0; k < 4; k++) mq.push_back(24'(word_data[8*k +: 8]));
          else if (pk) begin
            mq.push_back(24'(word_data[15:0]));
            mq.push_back(24'(word_data[31:16]));
          end else mq.push_back(word_data[23:0]);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      chk(pix_data == exp_d, tag_cur, "pix_data", pix_data, exp_d);
      chk(pix_underflow == exp_uf, (exp_uf ? "R10" : tag_cur), "pix_underflow",
          pix_underflow, exp_uf);
    end
  end

  task automatic set_cfg(input logic [1:0] bw, input logic [3:0] mk, input bit sw,
                         input bit inv, input string tag);
    @(negedge clk);
    word_valid = 1'b0; pix_req = 1'b0; fifo_clear = 1'b1;
    cfg_bus_width = bw; cfg_byte_mask = mk; cfg_swap_rb = sw; cfg_invert = inv;
    tag_cur = tag;
    @(negedge clk);
    fifo_clear = 1'b0;
  endtask

  task automatic drive(input int nwords, input int k, input int seed);
    int idx = 0;
    int cyc = 0;
    while (idx < nwords && cyc < 400) begin
      @(negedge clk);
      word_valid = 1'b1;
      word_data  = 32'(seed + idx) * 32'h9E3779B1 ^ 32'h5A3C_0F96;
      pix_req    = (cyc % k) == 0;
      #1;
      if (word_ready) idx++;
      cyc++;
    end
    @(negedge clk);
    word_valid = 1'b0;
    pix_req = 1'b1;
    repeat (10) @(negedge clk);
    pix_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [23:0] held;
    repeat (3) @(negedge clk);
    chk(pix_data == 24'h0, "R1", "reset pix_data", pix_data, 0);
    chk(pix_underflow == 1'b0, "R1", "reset underflow", pix_underflow, 0);
    chk(word_ready == 1'b1, "R1", "reset word_ready", word_ready, 1);
    rst_n = 1'b1;
    model_on = 1'b1;

    set_cfg(2'd0, 4'hF, 1'b0, 1'b0, "R3"); drive(6, 1, 1);
    set_cfg(2'd0, 4'hF, 1'b1, 1'b1, "R8"); drive(5, 2, 20);
    set_cfg(2'd2, 4'hF, 1'b0, 1'b0, "R4"); drive(4, 1, 40);
    set_cfg(2'd3, 4'hF, 1'b0, 1'b1, "R9"); drive(4, 3, 60);
    set_cfg(2'd3, 4'h7, 1'b0, 1'b0, "R5"); drive(6, 1, 80);
    set_cfg(2'd2, 4'h7, 1'b1, 1'b0, "R5"); drive(5, 2, 100);
    set_cfg(2'd0, 4'h7, 1'b0, 1'b1, "R5"); drive(5, 1, 120);
    set_cfg(2'd1, 4'hF, 1'b1, 1'b0, "R6"); drive(4, 1, 140);
    set_cfg(2'd1, 4'h7, 1'b0, 1'b1, "R7"); drive(3, 1, 160);

    // R6 explicit byte order
    set_cfg(2'd1, 4'hF, 1'b0, 1'b0, "R6");
    word_valid = 1'b1; word_data = 32'hD4C3B2A1;
    @(negedge clk); word_valid = 1'b0; pix_req = 1'b1;
    @(negedge clk); chk(pix_data == 24'hA1, "R6", "first byte", pix_data, 24'hA1);
    @(negedge clk); chk(pix_data == 24'hB2, "R6", "second byte", pix_data, 24'hB2);
    pix_req = 1'b0;
    // R11 hold without request
    held = pix_data;
    repeat (3) @(negedge clk);
    chk(pix_data == held, "R11", "hold without request", pix_data, held);

    // R10 explicit underflow
    set_cfg(2'd0, 4'hF, 1'b0, 1'b0, "R10");
    pix_req = 1'b1;
    @(negedge clk);
    chk(pix_underflow == 1'b1 && pix_data == 0, "R10", "underflow flag",
        pix_underflow, 1);
    pix_req = 1'b0;

    // R2 back-pressure
    set_cfg(2'd3, 4'h7, 1'b0, 1'b0, "R2");
    word_valid = 1'b1; word_data = 32'h00112233;
    @(negedge clk); word_data = 32'h00445566;
    #1 chk(word_ready == 1'b0, "R2", "ready low when held", word_ready, 0);
    repeat (3) @(negedge clk);
    pix_req = 1'b1;
    @(negedge clk);
    chk(pix_data == 24'h112233, "R2", "first word kept", pix_data, 24'h112233);
    word_valid = 1'b0;
    @(negedge clk);
    chk(pix_data == 24'h445566, "R2", "waiting word next", pix_data, 24'h445566);
    pix_req = 1'b0;

    // R12 clear drops residual halfword
    set_cfg(2'd0, 4'hF, 1'b0, 1'b0, "R12");
    word_valid = 1'b1; word_data = 32'h1234ABCD;
    @(negedge clk); word_valid = 1'b0; pix_req = 1'b1;
    @(negedge clk);
    chk(pix_data == 24'h00ABCD, "R3", "lower halfword first", pix_data, 24'hABCD);
    pix_req = 1'b0; fifo_clear = 1'b1; word_valid = 1'b1; word_data = 32'h77777777;
    #1 chk(word_ready == 1'b1, "R12", "ready during clear", word_ready, 1);
    @(negedge clk);
    chk(pix_data == 0, "R12", "zero after clear", pix_data, 0);
    fifo_clear = 1'b0; word_valid = 1'b0; pix_req = 1'b1;
    @(negedge clk);
    chk(pix_underflow == 1'b1, "R12", "residual discarded", pix_underflow, 1);
    pix_req = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule